// File: doc/BRIEF.md
# Instruction Cycle Controller

This block is the control unit of a small accumulator machine. It steps each instruction through fetch, an optional indirect read, execute and an optional interrupt entry. It moves values between a memory address register, a memory buffer register, a program counter, an instruction register, an accumulator and a stack pointer. All traffic goes over one single-port memory. A request is held until the memory raises a ready strobe.

An instruction word is 16 bits wide. The top bit selects indirect addressing. The next three bits select the operation. The low twelve bits give an address. A status word holds the four arithmetic flags and an interrupt-enable bit. When an instruction ends with interrupts enabled and a request pending, the controller does the following:

- it saves the program counter at the stack location;
- it lowers the stack pointer;
- it masks further requests;
- it continues at a fixed handler address.

A return instruction undoes this sequence.

Top module: `icyc_ctrl`

## Requirements
- R1: A synchronous active-high reset sets the program counter to 0, the accumulator and all four flags to 0, interrupt-enable to 1 and the stack pointer to 0x0FF. In the cycle after reset, neither a read nor a write is requested.
- R2: A fetch copies the program counter to the address register and reads that address. When the read completes, the program counter has grown by exactly one.
- R3: A read or write request keeps its address and write data stable until the first cycle in which mem_ready is high, and that cycle ends it. mem_rd and mem_wr are never high together.
- R4: The instruction word is split as follows. Bit 15 is the indirect flag, bits 14:12 are the opcode and bits 11:0 are the address. Opcodes are 0 load, 1 store, 2 add, 3 jump, 4 return from interrupt and 7 halt. Opcodes 5 and 6 change no register and no memory word.
- R5: With bit 15 set, load, store, add and jump first read the word at the address field. The low 12 bits of that word then serve as the effective address.
- R6: psw bit 0 is zero, bit 1 is sign, bit 2 is carry-out, bit 3 is signed overflow and bit 4 is interrupt-enable. Only add changes bits 3:0, and it sets them from the 16-bit sum of accumulator and operand.
- R7: A store writes the accumulator to the effective address. A load copies the word at the effective address into the accumulator.
- R8: When an instruction ends with interrupt-enable set and irq high, the controller writes the zero-extended program counter to the address in the stack pointer. It then decrements the stack pointer, clears interrupt-enable and sets the program counter to 0x010.
- R9: While interrupt-enable is 0, a high irq starts no interrupt entry.
- R10: Return from interrupt increments the stack pointer and reads that location. It loads the low 12 bits of the word read into the program counter and sets interrupt-enable.
- R11: After a halt, the controller makes no memory request, holds the program counter and ignores irq until reset. It shows the halted state on halted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous reset, active high |
| mem_addr | output | 12 | memory address, from the address register |
| mem_wdata | output | 16 | write data, from the buffer register |
| mem_rdata | input | 16 | read data from memory |
| mem_rd | output | 1 | read request |
| mem_wr | output | 1 | write request |
| mem_ready | input | 1 | memory completes the current request |
| irq | input | 1 | interrupt request, level |
| pc | output | 12 | program counter |
| acc | output | 16 | accumulator |
| psw | output | 5 | status word {ie, v, c, n, z} |
| halted | output | 1 | controller is stopped by a halt |

## Verification
The add path is swept over every pair from a nine-value set made of zero, one, both sign boundaries, all-ones and mid-range values. For each pair, the bench computes the sum, the stored word and all four flags arithmetically. This separates carry from overflow, and zero from a sign-bit-only result. The wait-state count changes from run to run, so ready arriving at once and ready arriving late both occur for every access kind. Further programs cover the following cases:

- an indirect load, store and jump, where direct decoding would pick the wrong addresses;
- a load and no-op opcodes after a flag-setting add, which must leave the flags untouched;
- an interrupt held high through its own handler, which must enter exactly once and return to the saved point;
- irq raised after a halt, which must change nothing.

// File: rtl/icyc_pkg.sv
package icyc_pkg;

    localparam int DATA_W  = 16;
    localparam int ADDR_W  = 12;
    localparam int OP_W    = 3;
    localparam int IND_BIT = DATA_W - 1;
    localparam int OP_LSB  = ADDR_W;
    localparam int OP_MSB  = ADDR_W + OP_W - 1;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [OP_W-1:0] {
        OP_LOAD  = 3'd0,
        OP_STORE = 3'd1,
        OP_ADD   = 3'd2,
        OP_JUMP  = 3'd3,
        OP_RETI  = 3'd4,
        OP_NOP5  = 3'd5,
        OP_NOP6  = 3'd6,
        OP_HALT  = 3'd7
    } op_e;

    typedef enum logic [3:0] {
        ST_F_ADR,
        ST_F_RD,
        ST_DEC,
        ST_I_RD,
        ST_EXE,
        ST_O_RD,
        ST_O_WR,
        ST_R_RD,
        ST_CHK,
        ST_INT_WR,
        ST_HALT
    } st_e;

    typedef struct packed {
        logic v;
        logic c;
        logic n;
        logic z;
    } flag_t;

    typedef struct packed {
        logic  ie;
        flag_t fl;
    } psw_t;

    function automatic op_e word_op(input word_t w);
        return op_e'(w[OP_MSB:OP_LSB]);
    endfunction

    function automatic logic word_ind(input word_t w);
        return w[IND_BIT];
    endfunction

    function automatic addr_t word_ea(input word_t w);
        return w[ADDR_W-1:0];
    endfunction

    function automatic logic op_has_ea(input op_e op);
        return (op == OP_LOAD) || (op == OP_STORE) || (op == OP_ADD) || (op == OP_JUMP);
    endfunction

endpackage

// File: rtl/icyc_alu.sv
module icyc_alu
    import icyc_pkg::*;
(
    input  word_t a,
    input  word_t b,
    output word_t sum,
    output flag_t flags
);
    logic [DATA_W:0] wide;

    always_comb begin
        wide    = {1'b0, a} + {1'b0, b};
        sum     = wide[DATA_W-1:0];
        flags.z = (wide[DATA_W-1:0] == '0);
        flags.n = wide[DATA_W-1];
        flags.c = wide[DATA_W];
        flags.v = (a[DATA_W-1] == b[DATA_W-1]) && (wide[DATA_W-1] != a[DATA_W-1]);
    end
endmodule

// File: rtl/icyc_fsm.sv
module icyc_fsm
    import icyc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  mem_ready,
    input  word_t mbr,
    input  op_e   ir_op,
    input  logic  irq_take,
    output st_e   state,
    output logic  mem_rd,
    output logic  mem_wr
);
    st_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_F_ADR:  st_d = ST_F_RD;
            ST_F_RD:   if (mem_ready) st_d = ST_DEC;
            ST_DEC:    st_d = (word_ind(mbr) && op_has_ea(word_op(mbr))) ? ST_I_RD : ST_EXE;
            ST_I_RD:   if (mem_ready) st_d = ST_EXE;
            ST_EXE: begin
                case (ir_op)
                    OP_LOAD, OP_ADD: st_d = ST_O_RD;
                    OP_STORE:        st_d = ST_O_WR;
                    OP_RETI:         st_d = ST_R_RD;
                    OP_HALT:         st_d = ST_HALT;
                    default:         st_d = ST_CHK;
                endcase
            end
            ST_O_RD, ST_O_WR, ST_R_RD: if (mem_ready) st_d = ST_CHK;
            ST_CHK:    st_d = irq_take ? ST_INT_WR : ST_F_ADR;
            ST_INT_WR: if (mem_ready) st_d = ST_F_ADR;
            ST_HALT:   st_d = ST_HALT;
            default:   st_d = ST_F_ADR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_F_ADR;
        else     st_q <= st_d;
    end

    always_comb begin
        mem_rd = (st_q == ST_F_RD) || (st_q == ST_I_RD) || (st_q == ST_O_RD) || (st_q == ST_R_RD);
        mem_wr = (st_q == ST_O_WR) || (st_q == ST_INT_WR);
    end

    assign state = st_q;

    AST_HALT_STAY: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_HALT) |=> (st_q == ST_HALT) && !mem_rd && !mem_wr); // R11
    AST_RDWR_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr)); // R3
endmodule

// File: rtl/icyc_dpath.sv
module icyc_dpath
    import icyc_pkg::*;
#(
    parameter addr_t PC_RESET = 12'h000,
    parameter addr_t SP_RESET = 12'h0FF,
    parameter addr_t IRQ_VEC  = 12'h010,
    parameter bit    IE_RESET = 1'b1
) (
    input  logic  clk,
    input  logic  rst,
    input  st_e   state,
    input  logic  mem_ready,
    input  word_t mem_rdata,
    input  word_t alu_sum,
    input  flag_t alu_flags,
    output addr_t mar,
    output word_t mbr,
    output word_t ir,
    output addr_t pc,
    output word_t acc,
    output addr_t sp,
    output psw_t  psw
);
    localparam int PAD_W = DATA_W - ADDR_W;

    addr_t mar_q, pc_q, sp_q;
    word_t mbr_q, ir_q, acc_q;
    psw_t  psw_q;
    op_e   cur_op;

    assign cur_op = word_op(ir_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            mar_q     <= '0;
            mbr_q     <= '0;
            ir_q      <= '0;
            acc_q     <= '0;
            pc_q      <= PC_RESET;
            sp_q      <= SP_RESET;
            psw_q.ie  <= IE_RESET;
            psw_q.fl  <= '0;
        end else begin
            case (state)
                ST_F_ADR: mar_q <= pc_q;
                ST_F_RD: begin
                    if (mem_ready) begin
                        mbr_q <= mem_rdata;
                        pc_q  <= pc_q + ADDR_W'(1);
                    end
                end
                ST_DEC: begin
                    ir_q <= mbr_q;
                    if (word_ind(mbr_q) && op_has_ea(word_op(mbr_q)))
                        mar_q <= word_ea(mbr_q);
                end
                ST_I_RD: if (mem_ready) mbr_q <= mem_rdata;
                ST_EXE: begin
                    case (cur_op)
                        OP_LOAD, OP_ADD: mar_q <= word_ea(mbr_q);
                        OP_STORE: begin
                            mar_q <= word_ea(mbr_q);
                            mbr_q <= acc_q;
                        end
                        OP_JUMP: pc_q <= word_ea(mbr_q);
                        OP_RETI: begin
                            sp_q  <= sp_q + ADDR_W'(1);
                            mar_q <= sp_q + ADDR_W'(1);
                        end
                        default: ;
                    endcase
                end
                ST_O_RD: begin
                    if (mem_ready) begin
                        if (cur_op == OP_LOAD) begin
                            acc_q <= mem_rdata;
                        end else begin
                            acc_q    <= alu_sum;
                            psw_q.fl <= alu_flags;
                        end
                    end
                end
                ST_R_RD: begin
                    if (mem_ready) begin
                        pc_q     <= word_ea(mem_rdata);
                        psw_q.ie <= 1'b1;
                    end
                end
                ST_CHK: begin
                    mbr_q <= {{PAD_W{1'b0}}, pc_q};
                    mar_q <= sp_q;
                end
                ST_INT_WR: begin
                    if (mem_ready) begin
                        pc_q     <= IRQ_VEC;
                        sp_q     <= sp_q - ADDR_W'(1);
                        psw_q.ie <= 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    assign mar = mar_q;
    assign mbr = mbr_q;
    assign ir  = ir_q;
    assign pc  = pc_q;
    assign acc = acc_q;
    assign sp  = sp_q;
    assign psw = psw_q;
endmodule

// File: rtl/icyc_ctrl.sv
module icyc_ctrl
    import icyc_pkg::*;
#(
    parameter addr_t PC_RESET = 12'h000,
    parameter addr_t SP_RESET = 12'h0FF,
    parameter addr_t IRQ_VEC  = 12'h010,
    parameter bit    IE_RESET = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_rd,
    output logic              mem_wr,
    input  logic              mem_ready,
    input  logic              irq,
    output logic [ADDR_W-1:0] pc,
    output logic [DATA_W-1:0] acc,
    output logic [4:0]        psw,
    output logic              halted
);
    st_e   state;
    addr_t mar, pc_w, sp;
    word_t mbr, ir, acc_w, alu_sum;
    psw_t  psw_w;
    flag_t alu_flags;
    logic  irq_take;

    assign irq_take = psw_w.ie && irq;

    icyc_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .mem_ready (mem_ready),
        .mbr       (mbr),
        .ir_op     (word_op(ir)),
        .irq_take  (irq_take),
        .state     (state),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr)
    );

    icyc_alu u_alu (
        .a     (acc_w),
        .b     (mem_rdata),
        .sum   (alu_sum),
        .flags (alu_flags)
    );

    icyc_dpath #(
        .PC_RESET (PC_RESET),
        .SP_RESET (SP_RESET),
        .IRQ_VEC  (IRQ_VEC),
        .IE_RESET (IE_RESET)
    ) u_dpath (
        .clk       (clk),
        .rst       (rst),
        .state     (state),
        .mem_ready (mem_ready),
        .mem_rdata (mem_rdata),
        .alu_sum   (alu_sum),
        .alu_flags (alu_flags),
        .mar       (mar),
        .mbr       (mbr),
        .ir        (ir),
        .pc        (pc_w),
        .acc       (acc_w),
        .sp        (sp),
        .psw       (psw_w)
    );

    assign mem_addr  = mar;
    assign mem_wdata = mbr;
    assign pc        = pc_w;
    assign acc       = acc_w;
    assign psw       = psw_w;
    assign halted    = (state == ST_HALT);

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && !mem_ready) |=> mem_rd && $stable(mem_addr)); // R3
    AST_WR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_wr && !mem_ready) |=> mem_wr && $stable(mem_addr) && $stable(mem_wdata)); // R3
    AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
        (state == ST_F_RD && mem_ready) |=> pc_w == $past(mem_addr) + ADDR_W'(1)); // R2
    AST_SAVE_AT_SP: assert property (@(posedge clk) disable iff (rst)
        (state == ST_INT_WR) |-> mem_addr == sp && mem_wdata[ADDR_W-1:0] == pc_w); // R8
    AST_IE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (state == ST_INT_WR && mem_ready) |=> !psw_w.ie && pc_w == IRQ_VEC); // R8
    AST_RETI_IE: assert property (@(posedge clk) disable iff (rst)
        (state == ST_R_RD && mem_ready) |=> psw_w.ie); // R10
    AST_FLAGS_ADD_ONLY: assert property (@(posedge clk) disable iff (rst)
        !$stable(psw_w.fl) |-> $past(state) == ST_O_RD && $past(word_op(ir)) == OP_ADD); // R6
endmodule

// File: tb/icyc_ctrl_tb.sv
module icyc_ctrl_tb;
    localparam int CLK_T = 10;
    localparam int WDOG  = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] mem_addr;
    logic [15:0] mem_wdata, mem_rdata;
    logic        mem_rd, mem_wr, mem_ready;
    logic        irq = 1'b0;
    logic [11:0] pc;
    logic [15:0] acc;
    logic [4:0]  psw;
    logic        halted;

    logic [15:0] mem [0:255];
    int          wait_n = 0;
    int          wcnt = 0;
    int          save_cnt = 0;
    int          n_chk = 0;
    int          n_bad = 0;
    int          cyc = 0;

    always #(CLK_T/2) clk = ~clk;

    icyc_ctrl u_dut (
        .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_ready(mem_ready), .irq(irq), .pc(pc), .acc(acc), .psw(psw),
        .halted(halted)
    );

    assign mem_rdata = mem[mem_addr[7:0]];
    assign mem_ready = (wcnt == wait_n);

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_rd || mem_wr) wcnt <= (wcnt == wait_n) ? 0 : wcnt + 1;
        else                  wcnt <= 0;
        if (mem_wr && mem_ready) begin
            mem[mem_addr[7:0]] <= mem_wdata;
            if (mem_addr == 12'h0FF) save_cnt <= save_cnt + 1;
        end
        if (cyc > WDOG) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    function automatic logic [15:0] ins(input logic ind, input logic [2:0] op, input logic [11:0] a);
        return {ind, op, a};
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
        save_cnt = 0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk);
        @(negedge clk); rst = 1'b0;
    endtask

    task automatic run_to_halt();
        int n = 0;
        while (!halted && n < 3000) begin
            @(negedge clk);
            n++;
        end
        check("R11 halted reached", {15'd0, halted}, 16'd1);
    endtask

    logic [15:0] vals [0:8];
    logic [16:0] wide;
    logic [15:0] s;
    logic [4:0]  ef;
    logic [11:0] pc_hold;
    int          req_cnt;
    int          sc_hold;

    initial begin
        vals[0] = 16'h0000; vals[1] = 16'h0001; vals[2] = 16'h7FFF;
        vals[3] = 16'h8000; vals[4] = 16'hFFFF; vals[5] = 16'h1234;
        vals[6] = 16'h8001; vals[7] = 16'h4000; vals[8] = 16'hC000;

        // R1: reset state
        clear_mem();
        @(negedge clk); rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R1 pc", {4'd0, pc}, 16'h0000);
        check("R1 acc", acc, 16'h0000);
        check("R1 psw", {11'd0, psw}, 16'h0010);
        check("R1 no request", {14'd0, mem_rd, mem_wr}, 16'h0000);
        check("R1 not halted", {15'd0, halted}, 16'h0000);

        // R6 R7 R2 R3: add sweep with varying wait states
        for (int i = 0; i < 9; i++) begin
            for (int j = 0; j < 9; j++) begin
                clear_mem();
                wait_n = (i + j) % 3;
                mem[0] = ins(1'b0, 3'd0, 12'h040);
                mem[1] = ins(1'b0, 3'd2, 12'h041);
                mem[2] = ins(1'b0, 3'd1, 12'h042);
                mem[3] = ins(1'b0, 3'd7, 12'h000);
                mem[8'h40] = vals[i];
                mem[8'h41] = vals[j];
                do_reset();
                run_to_halt();
                wide = {1'b0, vals[i]} + {1'b0, vals[j]};
                s = wide[15:0];
                ef = {1'b1, (vals[i][15] == vals[j][15]) && (s[15] != vals[i][15]),
                      wide[16], s[15], s == 16'h0000};
                check("R6 add result", acc, s);
                check("R6 flags", {11'd0, psw}, {11'd0, ef});
                check("R7 stored word", mem[8'h42], s);
                check("R2 pc after halt", {4'd0, pc}, 16'h0004);
            end
        end

        // R6 R4: load and opcodes 5/6 keep flags; no-ops change nothing
        clear_mem();
        wait_n = 1;
        mem[0] = ins(1'b0, 3'd0, 12'h040);
        mem[1] = ins(1'b0, 3'd2, 12'h041);
        mem[2] = ins(1'b0, 3'd0, 12'h043);
        mem[3] = ins(1'b0, 3'd5, 12'h040);
        mem[4] = ins(1'b1, 3'd6, 12'h040);
        mem[5] = ins(1'b0, 3'd7, 12'h000);
        mem[8'h40] = 16'h8000; mem[8'h41] = 16'h8000; mem[8'h43] = 16'h0001;
        do_reset();
        run_to_halt();
        check("R6 flags kept by load", {11'd0, psw}, 16'h001D);
        check("R4 no-op acc", acc, 16'h0001);
        check("R4 no-op memory", mem[8'h40], 16'h8000);
        check("R4 pc", {4'd0, pc}, 16'h0006);

        // R5: indirect load, store, jump
        clear_mem();
        wait_n = 2;
        mem[0] = ins(1'b1, 3'd0, 12'h050);
        mem[1] = ins(1'b1, 3'd1, 12'h051);
        mem[2] = ins(1'b1, 3'd3, 12'h052);
        mem[3] = ins(1'b0, 3'd7, 12'h000);
        mem[4] = ins(1'b0, 3'd7, 12'h000);
        mem[5] = ins(1'b0, 3'd2, 12'h053);
        mem[6] = ins(1'b0, 3'd7, 12'h000);
        mem[8'h50] = 16'hF060; mem[8'h60] = 16'hBEEF;
        mem[8'h51] = 16'h0061; mem[8'h52] = 16'h0005; mem[8'h53] = 16'h0001;
        do_reset();
        run_to_halt();
        check("R5 indirect load+add", acc, 16'hBEF0);
        check("R5 indirect store", mem[8'h61], 16'hBEEF);
        check("R5 pointer untouched", mem[8'h51], 16'h0061);
        check("R5 indirect jump pc", {4'd0, pc}, 16'h0007);

        // R8 R9 R10: interrupt held high through its handler
        clear_mem();
        wait_n = 1;
        mem[0] = ins(1'b0, 3'd3, 12'h020);
        mem[8'h10] = ins(1'b0, 3'd0, 12'h070);
        mem[8'h11] = ins(1'b0, 3'd2, 12'h071);
        mem[8'h12] = ins(1'b0, 3'd1, 12'h072);
        mem[8'h13] = ins(1'b0, 3'd4, 12'h000);
        mem[8'h20] = ins(1'b0, 3'd0, 12'h073);
        mem[8'h21] = ins(1'b0, 3'd2, 12'h074);
        mem[8'h22] = ins(1'b0, 3'd1, 12'h075);
        mem[8'h23] = ins(1'b0, 3'd7, 12'h000);
        mem[8'h70] = 16'h0100; mem[8'h71] = 16'h0023;
        mem[8'h73] = 16'h0005; mem[8'h74] = 16'h0003;
        irq = 1'b1;
        do_reset();
        do @(negedge clk); while (!(mem_rd && mem_addr == 12'h012));
        check("R8 ie cleared in handler", {15'd0, psw[4]}, 16'h0000);
        check("R8 saved pc", mem[8'hFF], 16'h0020);
        do @(negedge clk); while (!(mem_rd && mem_addr == 12'h013));
        check("R9 one entry while masked", save_cnt[15:0], 16'h0001);
        irq = 1'b0;
        run_to_halt();
        check("R8 handler store", mem[8'h72], 16'h0123);
        check("R10 resumed main", mem[8'h75], 16'h0008);
        check("R10 ie set", {11'd0, psw}, 16'h0010);
        check("R10 pc", {4'd0, pc}, 16'h0024);
        check("R9 total entries", save_cnt[15:0], 16'h0001);

        // R11: halted controller ignores irq
        pc_hold = pc;
        sc_hold = save_cnt;
        req_cnt = 0;
        irq = 1'b1;
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            if (mem_rd || mem_wr) req_cnt++;
        end
        irq = 1'b0;
        check("R11 no requests", req_cnt[15:0], 16'h0000);
        check("R11 pc held", {4'd0, pc}, {4'd0, pc_hold});
        check("R11 no entry", save_cnt[15:0], sc_hold[15:0]);
        check("R11 still halted", {15'd0, halted}, 16'h0001);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule